// File: doc/BRIEF.md
# Configuration Channel Transaction Engine

This block holds a bank of oscillator-frequency configuration words and lets software read or program them through four 32-bit registers. Software first loads the word it wants to send into a data-out register. It then writes a control word that selects a device index and a function code, and carries a direction bit and a start bit. When start is set, the engine checks the request and performs it. A good write copies data-out into the chosen oscillator word. A good read copies the chosen word into a read-return register. In both cases the engine reports done, and it adds an error flag when the request is refused.

Each control write clears the status before anything else happens. The outcome of a started request appears in the status register on the clock edge that accepts the control write, so the status can be read back on the next bus access. The number of oscillator words and their reset values are parameters. The whole bank is also driven onto an output port, so that neighbouring logic can use the current settings.

Top module: `cfgchan_top`

## Requirements
- R1: Offset 0xA0 reads the read-return register, 0xA4 the data-out register, 0xA8 the control register and 0xAC the status register. Any other offset reads as zero, and writes to it have no effect.
- R2: A write to 0xA4 stores the full 32-bit value, which reads back unchanged.
- R3: A control write stores only the device index [11:0], the function code [25:20] and the direction bit 30. Bits [19:12], [29:26] and the start bit 31 always read back as zero.
- R4: Every control write clears the status. A control write with bit 31 low leaves status at zero and touches neither the oscillator bank nor the read-return register.
- R5: A started write (bit 31 = 1, bit 30 = 1, function 1, device below the word count) copies data-out into the selected oscillator word and sets status to 0x1.
- R6: A started read (bit 31 = 1, bit 30 = 0, function 1, device below the word count) loads the selected oscillator word into read-return and sets status to 0x1.
- R7: A started request whose function code is not 1 sets status to 0x3. It leaves every oscillator word and the read-return register unchanged.
- R8: A started request whose device index is at or above the word count sets status to 0x3. It leaves every oscillator word and the read-return register unchanged.
- R9: After reset, control reads 0x00100000, while status, data-out and read-return read zero. Each oscillator word holds its own parameterised initial value.
- R10: Writes to the read-return and status offsets are ignored. The status changes only on a control write.
- R11: Status bit 0 is done and bit 1 is error. Bits [31:2] always read as zero.
- R12: The oscillator bank output carries word i on bits [32*i+31 : 32*i].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busSel | input | 1 | Register access strobe for this cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | ADDR_W | Byte offset of the register |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, combinational from the addressed register |
| oscWords | output | 32*NUM_OSC | Current contents of the oscillator bank |

## Verification
The checker watches every cycle for the following rules:
- the status outcome that follows each control write: cleared when start is low, done when start is high, and done with error for a bad function code or device index;
- status does not move without a control write;
- the upper status bits stay zero;
- the data-out register captures the written value;
- the oscillator bank stays still unless a started write is accepted.

Some behaviour can only be shown by the bench's scenarios:
- the register map and control-field masking as seen through reads;
- which oscillator word a valid access actually selects;
- read-return holding its old value after a refused read;
- the full reset image, including the parameterised oscillator values after a reset in the middle of a run.

// File: rtl/cfgchan_pkg.sv
package cfgchan_pkg;

  localparam int DATA_W  = 32;
  localparam int DEV_W   = 12;
  localparam int FN_LSB  = 20;
  localparam int FN_W    = 6;
  localparam int DIR_BIT = 30;
  localparam int GO_BIT  = 31;

  // Register offsets (byte addresses)
  localparam logic [7:0] OFF_RTN  = 8'hA0;
  localparam logic [7:0] OFF_DOUT = 8'hA4;
  localparam logic [7:0] OFF_CTRL = 8'hA8;
  localparam logic [7:0] OFF_STAT = 8'hAC;

  // Bits of the control word that are kept: device, function, direction
  localparam logic [DATA_W-1:0] CTRL_KEEP  = 32'h43F0_0FFF;
  localparam logic [DATA_W-1:0] CTRL_RESET = 32'h0010_0000;
  localparam logic [FN_W-1:0]   FN_OSC     = 6'd1;

  typedef enum logic [2:0] {
    RD_ZERO,
    RD_RTN,
    RD_DOUT,
    RD_CTRL,
    RD_STAT
  } rdsel_e;

  // Strobes from control to datapath for one bus cycle
  typedef struct packed {
    logic loadDout;
    logic loadCtrl;
    logic setDone;
    logic setError;
    logic oscWrite;
    logic rtnLoad;
  } strobe_t;

endpackage

// File: rtl/cfgchan_ctrl.sv
module cfgchan_ctrl
  import cfgchan_pkg::*;
#(
  parameter int NUM_OSC = 3,
  parameter int ADDR_W  = 8,
  parameter int IDX_W   = (NUM_OSC > 1) ? $clog2(NUM_OSC) : 1
) (
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output strobe_t           strb,
  output logic [IDX_W-1:0]  oscIdx,
  output rdsel_e            rdSel
);

  logic hitRtn, hitDout, hitCtrl, hitStat;
  logic ctrlWr, goReq, fnOk, devOk, reqOk;
  logic [DEV_W-1:0] devField;
  logic [FN_W-1:0]  fnField;

  assign hitRtn  = (busAddr == ADDR_W'(OFF_RTN));
  assign hitDout = (busAddr == ADDR_W'(OFF_DOUT));
  assign hitCtrl = (busAddr == ADDR_W'(OFF_CTRL));
  assign hitStat = (busAddr == ADDR_W'(OFF_STAT));

  assign devField = busWdata[DEV_W-1:0];
  assign fnField  = busWdata[FN_LSB +: FN_W];

  assign ctrlWr = busSel && busWrite && hitCtrl;
  assign goReq  = ctrlWr && busWdata[GO_BIT];
  assign fnOk   = (fnField == FN_OSC);
  assign devOk  = (devField < DEV_W'(NUM_OSC));
  assign reqOk  = fnOk && devOk;

  always_comb begin
    strb          = '0;
    strb.loadDout = busSel && busWrite && hitDout;
    strb.loadCtrl = ctrlWr;
    strb.setDone  = goReq;
    strb.setError = goReq && !reqOk;
    strb.oscWrite = goReq && reqOk && busWdata[DIR_BIT];
    strb.rtnLoad  = goReq && reqOk && !busWdata[DIR_BIT];
  end

  assign oscIdx = devField[IDX_W-1:0];

  always_comb begin
    rdSel = RD_ZERO;
    if (hitRtn)       rdSel = RD_RTN;
    else if (hitDout) rdSel = RD_DOUT;
    else if (hitCtrl) rdSel = RD_CTRL;
    else if (hitStat) rdSel = RD_STAT;
  end

endmodule

// File: rtl/cfgchan_datapath.sv
module cfgchan_datapath
  import cfgchan_pkg::*;
#(
  parameter int                        NUM_OSC  = 3,
  parameter int                        IDX_W    = (NUM_OSC > 1) ? $clog2(NUM_OSC) : 1,
  parameter logic [NUM_OSC*DATA_W-1:0] OSC_INIT = '0
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  strobe_t                     strb,
  input  logic [IDX_W-1:0]            oscIdx,
  input  rdsel_e                      rdSel,
  input  logic [DATA_W-1:0]           busWdata,
  output logic [DATA_W-1:0]           busRdata,
  output logic [DATA_W-1:0]           statusQ,
  output logic [DATA_W-1:0]           doutQ,
  output logic [DATA_W-1:0]           rtnQ,
  output logic [NUM_OSC*DATA_W-1:0]   oscWords
);

  logic [DATA_W-1:0] ctrlQ;
  logic [1:0]        statBits;
  logic [DATA_W-1:0] oscQ [NUM_OSC];
  logic [DATA_W-1:0] selWord;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      doutQ <= '0;
    end else if (strb.loadDout) begin
      doutQ <= busWdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlQ    <= CTRL_RESET;
      statBits <= 2'b00;
    end else if (strb.loadCtrl) begin
      ctrlQ    <= busWdata & CTRL_KEEP;
      statBits <= {strb.setError, strb.setDone};
    end
  end

  assign statusQ = {{(DATA_W-2){1'b0}}, statBits};

  for (genvar i = 0; i < NUM_OSC; i++) begin : g_osc
    always_ff @(posedge clk) begin
      if (!rstN) begin
        oscQ[i] <= OSC_INIT[i*DATA_W +: DATA_W];
      end else if (strb.oscWrite && (oscIdx == IDX_W'(i))) begin
        oscQ[i] <= doutQ;
      end
    end
    assign oscWords[i*DATA_W +: DATA_W] = oscQ[i];
  end

  always_comb begin
    selWord = '0;
    for (int i = 0; i < NUM_OSC; i++) begin
      if (oscIdx == IDX_W'(i)) selWord = oscQ[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rtnQ <= '0;
    end else if (strb.rtnLoad) begin
      rtnQ <= selWord;
    end
  end

  always_comb begin
    unique case (rdSel)
      RD_RTN:  busRdata = rtnQ;
      RD_DOUT: busRdata = doutQ;
      RD_CTRL: busRdata = ctrlQ;
      RD_STAT: busRdata = statusQ;
      default: busRdata = '0;
    endcase
  end

endmodule

// File: rtl/cfgchan_top.sv
module cfgchan_top
  import cfgchan_pkg::*;
#(
  parameter int                        NUM_OSC  = 3,
  parameter int                        ADDR_W   = 8,
  parameter logic [NUM_OSC*DATA_W-1:0] OSC_INIT = {32'h00BE_BC20, 32'h017D_7840, 32'h02FA_F080}
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        busSel,
  input  logic                        busWrite,
  input  logic [ADDR_W-1:0]           busAddr,
  input  logic [31:0]                 busWdata,
  output logic [31:0]                 busRdata,
  output logic [NUM_OSC*32-1:0]       oscWords
);

  localparam int IDX_W = (NUM_OSC > 1) ? $clog2(NUM_OSC) : 1;

  strobe_t           strb;
  logic [IDX_W-1:0]  oscIdx;
  rdsel_e            rdSel;
  logic [DATA_W-1:0] statusQ;
  logic [DATA_W-1:0] doutQ;
  logic [DATA_W-1:0] rtnQ;

  cfgchan_ctrl #(
    .NUM_OSC (NUM_OSC),
    .ADDR_W  (ADDR_W),
    .IDX_W   (IDX_W)
  ) ctrl_i (
    .busSel   (busSel),
    .busWrite (busWrite),
    .busAddr  (busAddr),
    .busWdata (busWdata),
    .strb     (strb),
    .oscIdx   (oscIdx),
    .rdSel    (rdSel)
  );

  cfgchan_datapath #(
    .NUM_OSC  (NUM_OSC),
    .IDX_W    (IDX_W),
    .OSC_INIT (OSC_INIT)
  ) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .oscIdx   (oscIdx),
    .rdSel    (rdSel),
    .busWdata (busWdata),
    .busRdata (busRdata),
    .statusQ  (statusQ),
    .doutQ    (doutQ),
    .rtnQ     (rtnQ),
    .oscWords (oscWords)
  );

endmodule

// File: rtl/cfgchan_checker.sv
module cfgchan_checker #(
  parameter int NUM_OSC = 3,
  parameter int ADDR_W  = 8
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  busSel,
  input logic                  busWrite,
  input logic [ADDR_W-1:0]     busAddr,
  input logic [31:0]           busWdata,
  input logic [31:0]           statusQ,
  input logic [31:0]           doutQ,
  input logic [31:0]           rtnQ,
  input logic [NUM_OSC*32-1:0] oscWords
);

  logic ctrlWr, doutWr, goBit, badFn, badDev, goodWrite;

  assign ctrlWr    = busSel && busWrite && (busAddr == ADDR_W'(8'hA8));
  assign doutWr    = busSel && busWrite && (busAddr == ADDR_W'(8'hA4));
  assign goBit     = busWdata[31];
  assign badFn     = (busWdata[25:20] != 6'd1);
  assign badDev    = ({20'd0, busWdata[11:0]} >= NUM_OSC);
  assign goodWrite = ctrlWr && goBit && busWdata[30] && !badFn && !badDev;

  assert_stat_clear_R4: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWr && !goBit) |=> (statusQ == 32'd0));

  assert_done_set_R5: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWr && goBit) |=> statusQ[0]);

  assert_bad_fn_R7: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWr && goBit && badFn) |=> (statusQ[1:0] == 2'b11) && $stable(oscWords) && $stable(rtnQ));

  assert_bad_dev_R8: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWr && goBit && badDev) |=> (statusQ[1:0] == 2'b11) && $stable(oscWords) && $stable(rtnQ));

  assert_stat_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlWr |=> $stable(statusQ));

  assert_stat_upper_R11: assert property (@(posedge clk) disable iff (!rstN)
    statusQ[31:2] == 30'd0);

  assert_dout_load_R2: assert property (@(posedge clk) disable iff (!rstN)
    doutWr |=> (doutQ == $past(busWdata)));

  assert_bank_quiet_R5: assert property (@(posedge clk) disable iff (!rstN)
    !goodWrite |=> $stable(oscWords));

endmodule

bind cfgchan_top cfgchan_checker #(
  .NUM_OSC (NUM_OSC),
  .ADDR_W  (ADDR_W)
) checker_i (
  .clk      (clk),
  .rstN     (rstN),
  .busSel   (busSel),
  .busWrite (busWrite),
  .busAddr  (busAddr),
  .busWdata (busWdata),
  .statusQ  (statusQ),
  .doutQ    (doutQ),
  .rtnQ     (rtnQ),
  .oscWords (oscWords)
);

// File: tb/cfgchan_top_tb_top.sv
`timescale 1ns/1ps
module cfgchan_top_tb_top;

  localparam int NUM_OSC = 3;
  localparam int ADDR_W  = 8;
  localparam logic [31:0] INIT0 = 32'h02FA_F080;
  localparam logic [31:0] INIT1 = 32'h017D_7840;
  localparam logic [31:0] INIT2 = 32'h00BE_BC20;

  typedef struct packed {
    logic        isWrite;
    logic [7:0]  addr;
    logic [31:0] data;
    logic [7:0]  req;
  } vec_t;

  localparam int NVEC = 37;
  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 8'hA8, 32'h0010_0000, 8'd9},   // R9 control reset value
    '{1'b0, 8'hAC, 32'h0000_0000, 8'd9},   // R9 status reset
    '{1'b0, 8'hA0, 32'h0000_0000, 8'd9},   // R9 read-return reset
    '{1'b0, 8'hA4, 32'h0000_0000, 8'd9},   // R9 data-out reset
    '{1'b1, 8'hA4, 32'h1234_5678, 8'd2},   // R2 load data-out
    '{1'b0, 8'hA4, 32'h1234_5678, 8'd2},
    '{1'b1, 8'hA8, 32'h8010_0001, 8'd6},   // R6 read device 1
    '{1'b0, 8'hAC, 32'h0000_0001, 8'd6},
    '{1'b0, 8'hA0, 32'h017D_7840, 8'd6},
    '{1'b0, 8'hA8, 32'h0010_0001, 8'd3},   // R3 start not stored
    '{1'b1, 8'hA8, 32'hC010_0002, 8'd5},   // R5 write device 2
    '{1'b0, 8'hAC, 32'h0000_0001, 8'd5},
    '{1'b1, 8'hA8, 32'h8010_0002, 8'd5},   // R5 read it back
    '{1'b0, 8'hA0, 32'h1234_5678, 8'd5},
    '{1'b1, 8'hA8, 32'h8020_0000, 8'd7},   // R7 function 2
    '{1'b0, 8'hAC, 32'h0000_0003, 8'd7},
    '{1'b0, 8'hA0, 32'h1234_5678, 8'd7},
    '{1'b1, 8'hA8, 32'h0010_0000, 8'd4},   // R4 no start clears status
    '{1'b0, 8'hAC, 32'h0000_0000, 8'd4},
    '{1'b1, 8'hA8, 32'hC010_0003, 8'd8},   // R8 device 3 write
    '{1'b0, 8'hAC, 32'h0000_0003, 8'd8},
    '{1'b1, 8'hA8, 32'hFFFF_FFFF, 8'd3},   // R3 all ones
    '{1'b0, 8'hA8, 32'h43F0_0FFF, 8'd3},
    '{1'b0, 8'hAC, 32'h0000_0003, 8'd7},   // R7 function 0x3F
    '{1'b1, 8'hAC, 32'h0000_0000, 8'd10},  // R10 status write ignored
    '{1'b0, 8'hAC, 32'h0000_0003, 8'd10},
    '{1'b1, 8'hA0, 32'hDEAD_BEEF, 8'd10},  // R10 read-return write ignored
    '{1'b0, 8'hA0, 32'h1234_5678, 8'd10},
    '{1'b0, 8'h00, 32'h0000_0000, 8'd1},   // R1 unmapped reads zero
    '{1'b1, 8'h10, 32'h0000_0123, 8'd1},
    '{1'b0, 8'h10, 32'h0000_0000, 8'd1},
    '{1'b1, 8'hA8, 32'h8010_0000, 8'd6},   // R6 read device 0
    '{1'b0, 8'hA0, INIT0,         8'd6},
    '{1'b0, 8'hAC, 32'h0000_0001, 8'd11},  // R11 upper bits zero
    '{1'b1, 8'hA8, 32'h8010_0003, 8'd8},   // R8 read device 3
    '{1'b0, 8'hA0, INIT0,         8'd8},
    '{1'b0, 8'hAC, 32'h0000_0003, 8'd8}
  };

  logic                  clk = 1'b0;
  logic                  rstN = 1'b0;
  logic                  busSel = 1'b0;
  logic                  busWrite = 1'b0;
  logic [ADDR_W-1:0]     busAddr = '0;
  logic [31:0]           busWdata = '0;
  logic [31:0]           busRdata;
  logic [NUM_OSC*32-1:0] oscWords;

  int nChecks = 0;
  int nFails  = 0;

  always #4 clk = ~clk;

  cfgchan_top #(.NUM_OSC(NUM_OSC), .ADDR_W(ADDR_W)) dut_i (
    .clk      (clk),
    .rstN     (rstN),
    .busSel   (busSel),
    .busWrite (busWrite),
    .busAddr  (busAddr),
    .busWdata (busWdata),
    .busRdata (busRdata),
    .oscWords (oscWords)
  );

  task automatic check(input int req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL R%0d: got %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic busWr(input logic [7:0] addr, input logic [31:0] data);
    @(negedge clk);
    busSel = 1'b1; busWrite = 1'b1; busAddr = addr; busWdata = data;
  endtask

  task automatic busRd(input int req, input logic [7:0] addr, input logic [31:0] exp);
    @(negedge clk);
    busSel = 1'b1; busWrite = 1'b0; busAddr = addr; busWdata = '0;
    #1;
    check(req, busRdata, exp);
  endtask

  task automatic idle();
    @(negedge clk);
    busSel = 1'b0; busWrite = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    nFails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      if (VECS[i].isWrite) busWr(VECS[i].addr, VECS[i].data);
      else                 busRd(int'(VECS[i].req), VECS[i].addr, VECS[i].data);
    end
    idle();
    #1;
    // R12 word placement, R8 refused write left device range intact
    check(12, oscWords[31:0],  INIT0);
    check(12, oscWords[63:32], INIT1);
    check(8,  oscWords[95:64], 32'h1234_5678);

    // R5 write device 0 and observe the bank port
    busWr(8'hA4, 32'hAABB_CCDD);
    busWr(8'hA8, 32'hC010_0000);
    idle();
    #1;
    check(5, oscWords[31:0], 32'hAABB_CCDD);
    check(5, oscWords[63:32], INIT1);

    // R9 reset in mid-run restores everything
    @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    #1;
    check(9, oscWords[31:0],  INIT0);
    check(9, oscWords[95:64], INIT2);
    busRd(9, 8'hA8, 32'h0010_0000);
    busRd(9, 8'hA4, 32'h0000_0000);
    busRd(9, 8'hA0, 32'h0000_0000);
    busRd(9, 8'hAC, 32'h0000_0000);
    idle();

    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule